// File: doc/BRIEF.md
# FIFO Occupancy and Watermark Unit

This block holds the two data queues of a byte-serial bus controller. The transmit queue is loaded from the register side and emptied by the serial engine. The receive queue is loaded by the serial engine and emptied by register reads. Each queue has its own flop storage, read and write pointers and entry counter. Reads are fall-through: the oldest entry is always present on the pop data port.

Software sees each queue through a zero-based occupancy value and a status byte holding the full and empty flags. A programmable zero-based receive level decides when the receive interrupt condition rises. This lets a driver be woken after any chosen number of bytes, not only when the queue is full. The transmit side provides two conditions: drained completely, and drained to half depth. A held flush input clears the transmit queue.

Top module: `fq_occ_unit`

## Requirements
- R1: After reset both queues are empty, both occupancy outputs are 0, the status byte is 8'hC0, `irq_tx_empty` and `irq_tx_half` are 1, and `irq_rx_level` is 0.
- R2: Each queue returns its entries in the order they were accepted. The oldest entry is visible on the pop data port during the cycle in which it is popped.
- R3: An occupancy output shows the entry count minus one, and shows 0 when the queue is empty.
- R4: A push to a queue holding DEPTH entries is dropped. Its occupancy and contents stay unchanged.
- R5: A pop from an empty queue is dropped. The queue stays empty.
- R6: `irq_rx_level` is 1 exactly when the receive entry count is at least `rx_level` + 1. `rx_level` is zero-based.
- R7: `irq_tx_half` is 1 exactly when the transmit entry count is at most DEPTH/2.
- R8: Status byte: bit 7 is transmit empty, bit 6 is receive empty, bit 5 is receive full, bit 4 is transmit full, and bits 3..0 are 0. `irq_tx_empty` follows transmit empty.
- R9: While `tx_flush` is 1, the transmit queue is empty from the next cycle on, and transmit pushes and pops are dropped. The receive queue is not affected.
- R10: A push and a pop on the same queue in the same cycle are both taken when the queue is neither empty nor full, leaving the count unchanged. On an empty queue only the push is taken. On a full queue only the pop is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Register-side write into the transmit queue |
| tx_push_data | input | TX_W | Transmit write data |
| tx_pop | input | 1 | Serial engine takes the oldest transmit entry |
| tx_pop_data | output | TX_W | Oldest transmit entry |
| tx_flush | input | 1 | Hold-to-clear for the transmit queue |
| rx_push | input | 1 | Serial engine stores a received byte |
| rx_push_data | input | RX_W | Received data |
| rx_pop | input | 1 | Register-side read of the receive queue |
| rx_pop_data | output | RX_W | Oldest receive entry |
| rx_level | input | log2(DEPTH) | Zero-based receive watermark |
| tx_occ | output | log2(DEPTH) | Zero-based transmit occupancy |
| rx_occ | output | log2(DEPTH) | Zero-based receive occupancy |
| status | output | 8 | Queue flags (bits 7..4) |
| irq_rx_level | output | 1 | Receive watermark reached |
| irq_tx_empty | output | 1 | Transmit queue empty |
| irq_tx_half | output | 1 | Transmit queue at or below half depth |

## Verification
Two events can land on one queue in the same cycle: a push and a pop. On the transmit side, a flush can also coincide with a push or a pop. The bench drives push and pop together on half-filled, empty and full queues, and drives flush with pushes and pops pending. Each outcome is judged against a queue model that applies the dropping rules in the required order. The model predicts the popped data, both occupancies, the status byte and the three interrupt conditions one cycle later.

// File: rtl/fq_pkg.sv
package fq_pkg;
   // Flag bit positions inside the status byte; a register decoder reads them.
   localparam int unsigned ST_TX_FULL  = 4;
   localparam int unsigned ST_RX_FULL  = 5;
   localparam int unsigned ST_RX_EMPTY = 6;
   localparam int unsigned ST_TX_EMPTY = 7;

   typedef struct packed {
      logic empty;
      logic full;
      logic level_hit;
   } fq_flag_t;

   function automatic logic [7:0] fq_status(input fq_flag_t tx, input fq_flag_t rx);
      logic [7:0] s;
      s = '0;
      s[ST_TX_FULL]  = tx.full;
      s[ST_RX_FULL]  = rx.full;
      s[ST_RX_EMPTY] = rx.empty;
      s[ST_TX_EMPTY] = tx.empty;
      return s;
   endfunction
endpackage

// File: rtl/fq_ptr.sv
module fq_ptr #(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          wr_req,
   input  logic          rd_req,
   output logic          wr_fire,
   output logic          rd_fire,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   // Flush wins over both sides; a full queue refuses writes, an empty one reads.
   assign wr_fire = wr_req & ~flush & (count != FULL_CNT);
   assign rd_fire = rd_req & ~flush & (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waddr <= '0;
         raddr <= '0;
         count <= '0;
      end else if (flush) begin
         waddr <= '0;
         raddr <= '0;
         count <= '0;
      end else begin
         if (wr_fire) waddr <= waddr + 1'b1;
         if (rd_fire) raddr <= raddr + 1'b1;
         case ({wr_fire, rd_fire})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/fq_ram.sv
module fq_ram #(
   parameter int W              = 8,
   parameter int DEPTH          = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];
endmodule

// File: rtl/fq_flags.sv
module fq_flags #(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic [CW-1:0]    count,
   input  logic [AW-1:0]    thresh,
   output logic [AW-1:0]    occ,
   output fq_pkg::fq_flag_t flags
);
   logic [CW-1:0] cnt_m1;

   assign cnt_m1          = count - 1'b1;
   assign flags.empty     = (count == '0);
   assign flags.full      = (count == CW'(DEPTH));
   // count >= thresh + 1, written without widening the sum
   assign flags.level_hit = (count > {1'b0, thresh});
   assign occ             = flags.empty ? '0 : cnt_m1[AW-1:0];
endmodule

// File: rtl/fq_occ_unit.sv
module fq_occ_unit #(
   parameter int DEPTH       = 16,
   parameter int TX_W        = 10,
   parameter int RX_W        = 8,
   parameter bit STORE_RESET = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tx_push,
   input  logic [TX_W-1:0] tx_push_data,
   input  logic            tx_pop,
   output logic [TX_W-1:0] tx_pop_data,
   input  logic            tx_flush,
   input  logic            rx_push,
   input  logic [RX_W-1:0] rx_push_data,
   input  logic            rx_pop,
   output logic [RX_W-1:0] rx_pop_data,
   input  logic [AW-1:0]   rx_level,
   output logic [AW-1:0]   tx_occ,
   output logic [AW-1:0]   rx_occ,
   output logic [7:0]      status,
   output logic            irq_rx_level,
   output logic            irq_tx_empty,
   output logic            irq_tx_half
);
   import fq_pkg::*;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("fq_occ_unit: DEPTH must be a power of two of at least 2");
      end
      if (TX_W < 1 || RX_W < 1) begin : g_bad_width
         $error("fq_occ_unit: data widths must be positive");
      end
   endgenerate

   localparam logic [AW-1:0] TX_HALF_LVL = AW'(DEPTH / 2);

   // transmit queue
   logic          tx_wf, tx_rf;
   logic [AW-1:0] tx_wa, tx_ra;
   logic [CW-1:0] tx_cnt;
   fq_flag_t      tx_fl;

   fq_ptr #(.DEPTH(DEPTH)) u_tx_ptr (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .wr_req(tx_push), .rd_req(tx_pop),
      .wr_fire(tx_wf), .rd_fire(tx_rf),
      .waddr(tx_wa), .raddr(tx_ra), .count(tx_cnt)
   );

   fq_ram #(.W(TX_W), .DEPTH(DEPTH), .CLEAR_ON_RESET(STORE_RESET)) u_tx_ram (
      .clk(clk), .rst_n(rst_n), .we(tx_wf),
      .waddr(tx_wa), .wdata(tx_push_data),
      .raddr(tx_ra), .rdata(tx_pop_data)
   );

   fq_flags #(.DEPTH(DEPTH)) u_tx_flags (
      .count(tx_cnt), .thresh(TX_HALF_LVL), .occ(tx_occ), .flags(tx_fl)
   );

   // receive queue
   logic          rx_wf, rx_rf;
   logic [AW-1:0] rx_wa, rx_ra;
   logic [CW-1:0] rx_cnt;
   fq_flag_t      rx_fl;

   fq_ptr #(.DEPTH(DEPTH)) u_rx_ptr (
      .clk(clk), .rst_n(rst_n), .flush(1'b0),
      .wr_req(rx_push), .rd_req(rx_pop),
      .wr_fire(rx_wf), .rd_fire(rx_rf),
      .waddr(rx_wa), .raddr(rx_ra), .count(rx_cnt)
   );

   fq_ram #(.W(RX_W), .DEPTH(DEPTH), .CLEAR_ON_RESET(STORE_RESET)) u_rx_ram (
      .clk(clk), .rst_n(rst_n), .we(rx_wf),
      .waddr(rx_wa), .wdata(rx_push_data),
      .raddr(rx_ra), .rdata(rx_pop_data)
   );

   fq_flags #(.DEPTH(DEPTH)) u_rx_flags (
      .count(rx_cnt), .thresh(rx_level), .occ(rx_occ), .flags(rx_fl)
   );

   // rd_fire of both sides only advances pointers; kept visible for the checker
   logic rx_taken, tx_taken;
   assign rx_taken = rx_rf;
   assign tx_taken = tx_rf;

   assign status       = fq_status(tx_fl, rx_fl);
   assign irq_rx_level = rx_fl.level_hit;
   assign irq_tx_empty = tx_fl.empty;
   assign irq_tx_half  = ~tx_fl.level_hit;
endmodule

// File: rtl/fq_occ_unit_chk.sv
module fq_occ_unit_chk #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tx_push,
   input logic          tx_pop,
   input logic          tx_flush,
   input logic          rx_push,
   input logic          rx_pop,
   input logic [AW-1:0] tx_occ,
   input logic [AW-1:0] rx_occ,
   input logic [7:0]    status,
   input logic          irq_rx_level,
   input logic          irq_tx_empty,
   input logic          irq_tx_half
);
   p_occ_zero_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] |-> (tx_occ == '0));
   p_occ_zero_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      status[6] |-> (rx_occ == '0));
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status[4] && tx_push && !tx_pop && !tx_flush) |=> (status[4] && $stable(tx_occ)));
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status[6] && rx_pop && !rx_push) |=> status[6]);
   p_full_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      status[5] |-> irq_rx_level);
   p_level_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx_level |-> !status[6]);
   p_empty_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx_empty |-> irq_tx_half);
   p_full_not_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status[4] |-> !irq_tx_half);
   p_empty_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx_empty == status[7]);
   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |=> status[7]);
   p_pushpop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[7] && !status[4] && tx_push && tx_pop && !tx_flush) |=> $stable(tx_occ));
endmodule

bind fq_occ_unit fq_occ_unit_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .tx_push(tx_push), .tx_pop(tx_pop), .tx_flush(tx_flush),
   .rx_push(rx_push), .rx_pop(rx_pop),
   .tx_occ(tx_occ), .rx_occ(rx_occ), .status(status),
   .irq_rx_level(irq_rx_level), .irq_tx_empty(irq_tx_empty), .irq_tx_half(irq_tx_half)
);

// File: tb/tb_fq_occ_unit.sv
module tb_fq_occ_unit;
   localparam int DEPTH = 16;
   localparam int AW    = 4;
   localparam int TXW   = 10;
   localparam int RXW   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_push = 1'b0, tx_pop = 1'b0, tx_flush = 1'b0;
   logic rx_push = 1'b0, rx_pop = 1'b0;
   logic [TXW-1:0] tx_push_data = '0;
   logic [RXW-1:0] rx_push_data = '0;
   logic [AW-1:0]  rx_level = '0;
   logic [TXW-1:0] tx_pop_data;
   logic [RXW-1:0] rx_pop_data;
   logic [AW-1:0]  tx_occ, rx_occ;
   logic [7:0]     status;
   logic           irq_rx_level, irq_tx_empty, irq_tx_half;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [TXW-1:0] qtx[$];
   logic [RXW-1:0] qrx[$];

   always #10 clk = ~clk;

   fq_occ_unit #(.DEPTH(DEPTH), .TX_W(TXW), .RX_W(RXW)) dut (
      .clk(clk), .rst_n(rst_n),
      .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
      .tx_pop_data(tx_pop_data), .tx_flush(tx_flush),
      .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
      .rx_pop_data(rx_pop_data), .rx_level(rx_level),
      .tx_occ(tx_occ), .rx_occ(rx_occ), .status(status),
      .irq_rx_level(irq_rx_level), .irq_tx_empty(irq_tx_empty), .irq_tx_half(irq_tx_half)
   );

   task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, got, exp);
      end
   endtask

   function automatic logic [31:0] zocc(input int n);
      return (n == 0) ? 32'd0 : 32'(n - 1);
   endfunction

   // Compare every observable output against the queue model.
   task automatic check_outputs(input string ctx);
      int tn, rn;
      logic [7:0] st;
      tn = qtx.size();
      rn = qrx.size();
      st = {(tn == 0), (rn == 0), (rn == DEPTH), (tn == DEPTH), 4'b0000};
      check({ctx, " / R3 tx occupancy"}, 32'(tx_occ), zocc(tn));
      check({ctx, " / R3 rx occupancy"}, 32'(rx_occ), zocc(rn));
      check({ctx, " / R8 status byte"}, 32'(status), 32'(st));
      check({ctx, " / R6 rx watermark"}, 32'(irq_rx_level), 32'(rn >= int'(rx_level) + 1));
      check({ctx, " / R7 tx half"}, 32'(irq_tx_half), 32'(tn <= DEPTH / 2));
      check({ctx, " / R8 tx empty irq"}, 32'(irq_tx_empty), 32'(tn == 0));
   endtask

   // Driver: called at a falling edge; updates the expected queues and checks.
   task automatic step(input logic tpu, input logic [TXW-1:0] td, input logic tpo,
                       input logic tfl, input logic rpu, input logic [RXW-1:0] rd,
                       input logic rpo, input string ctx);
      bit t_push, t_pop, r_push, r_pop;
      tx_push = tpu; tx_push_data = td; tx_pop = tpo; tx_flush = tfl;
      rx_push = rpu; rx_push_data = rd; rx_pop = rpo;
      t_push = tpu && !tfl && (qtx.size() < DEPTH);
      t_pop  = tpo && !tfl && (qtx.size() > 0);
      r_push = rpu && (qrx.size() < DEPTH);
      r_pop  = rpo && (qrx.size() > 0);
      #2;
      if (t_pop) check({ctx, " / R2 tx pop data"}, 32'(tx_pop_data), 32'(qtx[0]));
      if (r_pop) check({ctx, " / R2 rx pop data"}, 32'(rx_pop_data), 32'(qrx[0]));
      if (tfl) qtx.delete();
      else begin
         if (t_pop) void'(qtx.pop_front());
         if (t_push) qtx.push_back(td);
      end
      if (r_pop) void'(qrx.pop_front());
      if (r_push) qrx.push_back(rd);
      @(posedge clk);
      @(negedge clk);
      tx_push = 1'b0; tx_pop = 1'b0; tx_flush = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
      check_outputs(ctx);
   endtask

   task automatic txw(input logic [TXW-1:0] d, input string c); step(1, d, 0, 0, 0, '0, 0, c); endtask
   task automatic txr(input string c); step(0, '0, 1, 0, 0, '0, 0, c); endtask
   task automatic rxw(input logic [RXW-1:0] d, input string c); step(0, '0, 0, 0, 1, d, 0, c); endtask
   task automatic rxr(input string c); step(0, '0, 0, 0, 0, '0, 1, c); endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: run still active, actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 tx occupancy", 32'(tx_occ), 0);
      check("R1 rx occupancy", 32'(rx_occ), 0);
      check("R1 status byte", 32'(status), 32'h0C0);
      check("R1 tx empty irq", 32'(irq_tx_empty), 1);
      check("R1 tx half irq", 32'(irq_tx_half), 1);
      check("R1 rx level irq", 32'(irq_rx_level), 0);

      for (int i = 0; i < DEPTH; i++) txw(TXW'(10'h100 + i * 7), "R2 tx fill");
      txw(10'h3FF, "R4 tx push when full");
      txw(10'h2AA, "R4 tx push when full");
      for (int i = 0; i < DEPTH; i++) txr("R2 tx drain");
      txr("R5 tx pop when empty");
      txr("R5 tx pop when empty");

      rx_level = 4'd3;
      for (int i = 0; i < 5; i++) rxw(RXW'(8'h40 + i), "R6 rx watermark at level 3");
      rx_level = 4'd5;
      step(0, '0, 0, 0, 0, '0, 0, "R6 level raised above count");
      rx_level = 4'd0;
      step(0, '0, 0, 0, 0, '0, 0, "R6 level lowered to zero");
      for (int i = 0; i < 5; i++) rxr("R2 rx drain");
      rxr("R5 rx pop when empty");
      rxr("R5 rx pop when empty");

      for (int i = 0; i < 6; i++) txw(TXW'(10'h050 + i), "R7 tx partial fill");
      for (int i = 0; i < 8; i++) step(1, TXW'(10'h1C0 + i), 1, 0, 0, '0, 0, "R10 tx push and pop");
      for (int i = 0; i < 3; i++) rxw(RXW'(8'h90 + i), "R10 rx preload");
      for (int i = 0; i < 6; i++) step(0, '0, 0, 0, 1, RXW'(8'hA0 + i), 1, "R10 rx push and pop");
      for (int i = 0; i < 3; i++) rxr("R10 rx drain");
      step(0, '0, 0, 0, 1, 8'h5A, 1, "R10 push and pop on empty rx");

      step(1, 10'h111, 0, 1, 0, '0, 0, "R9 flush with push");
      step(1, 10'h112, 0, 1, 0, '0, 0, "R9 flush held");
      step(0, '0, 1, 1, 0, '0, 0, "R9 flush with pop");
      txw(10'h0F0, "R9 push after flush release");
      txw(10'h0F1, "R9 push after flush release");
      txr("R9 pop after flush release");
      txr("R9 pop after flush release");

      rx_level = 4'd15;
      for (int i = 0; i < DEPTH - 1; i++) rxw(RXW'(8'hC0 + i), "R6 rx fill below level 15");
      rxw(8'hEE, "R6 rx reaches full level");
      rxw(8'hEF, "R4 rx push when full");
      step(0, '0, 0, 0, 1, 8'hF5, 1, "R10 push and pop on full rx");
      while (qrx.size() > 0) rxr("R2 rx final drain");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule